// File: doc/BRIEF.md
# Glitch-Free Dual-Clock Processor Switch

This block decides which of two free-running, unrelated clocks drives a shared system clock, and which of two processors is allowed to run. A single select request names the wanted source. The block hands over in a break-before-make order. It first withdraws the enable of the processor that is running. It then waits until that processor's clock gate is known to be off in the gate's own clock domain. Only after that does it open the incoming clock gate and raise the incoming processor's enable.

The select request never drives the clock multiplexer directly. Each clock branch captures it through its own synchronizer chain. Each branch also synchronizes the state of the other branch's gate. A gate register opens and closes only on the falling edge of its own clock, so every high phase on the output is a complete high phase of one source clock. Between the last pulse of the old source and the first pulse of the new one, the output rests low.

Top module: `cpu_clock_switch`

## Requirements
- R1: While `rst` is held high for at least four cycles of each clock, and after it is released, `cpu_a_en` is 1, `cpu_b_en` is 0, and `sys_clk` follows `clk_a`.
- R2: Encoding of `sel_b`: 0 requests source A, 1 requests source B. After a change of `sel_b`, the requested processor's enable ends up 1, the other ends up 0, and `sys_clk` follows the requested clock. `sel_b` must stay stable until the handover has completed.
- R3: `cpu_a_en` and `cpu_b_en` are never 1 at the same time.
- R4: The outgoing enable falls before the incoming enable rises. The incoming gate opens only while the outgoing gate is closed. Once the outgoing enable is low, no rising edge appears on `sys_clk` until the incoming enable is high.
- R5: Every high phase of `sys_clk` lasts exactly one full high phase of `clk_a` or `clk_b`. No low phase is shorter than the shorter of the two source low phases. A gate opens in the clock cycle after its enable rises.
- R6: The incoming enable rises no later than 12 periods of the slower clock after `sel_b` changes.
- R7: Writing `sel_b` with the value that is already selected leaves both enables and the source that `sys_clk` follows unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Free-running clock of processor A |
| clk_b | input | 1 | Free-running clock of processor B, unrelated to `clk_a` |
| rst | input | 1 | Active-high reset, synchronized separately into each clock domain |
| sel_b | input | 1 | Source request: 0 = A, 1 = B |
| sys_clk | output | 1 | Glitch-free system clock |
| cpu_a_en | output | 1 | Run enable for processor A, registered on `clk_a` |
| cpu_b_en | output | 1 | Run enable for processor B, registered on `clk_b` |

## Verification
The bench runs the two clocks at unrelated periods and moves the request at random, off-edge moments. It measures every pulse of `sys_clk`. A gate that toggled on the rising edge would leave a shortened high phase, and a gate that skipped its handshake would merge pulses from both sources; the width check catches both. For each handover the bench records when the old enable fell. A make-before-break design would show both enables high, or an extra output pulse inside the gap. The bench also writes requests that repeat the current source, where a design that re-armed its handshake would drop enables it should keep.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_e;

  // Source that owns the system clock out of reset
  localparam src_e RESET_SRC = SRC_A;

endpackage

// File: rtl/cksw_sync.sv
module cksw_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cksw_branch.sv
module cksw_branch #(
  parameter int STAGES   = 2,
  parameter bit RESET_ON = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic want,
  input  logic peer_gate,
  output logic run,
  output logic gate
);

  logic rst_s;
  logic want_s;
  logic peer_busy_s;

  // Reset brought into this clock domain
  cksw_sync #(.STAGES(STAGES), .INIT(1'b1)) u_rst_sync (
    .clk (clk),
    .rst (1'b0),
    .d   (rst),
    .q   (rst_s)
  );

  // Request level, captured before it may touch the clock path
  cksw_sync #(.STAGES(STAGES), .INIT(RESET_ON)) u_want_sync (
    .clk (clk),
    .rst (rst_s),
    .d   (want),
    .q   (want_s)
  );

  // State of the other branch's gate, seen in this domain
  cksw_sync #(.STAGES(STAGES), .INIT(!RESET_ON)) u_peer_sync (
    .clk (clk),
    .rst (rst_s),
    .d   (peer_gate),
    .q   (peer_busy_s)
  );

  // Enable: drops as soon as the request leaves, rises only with the peer closed
  always_ff @(posedge clk) begin
    if (rst_s) run <= RESET_ON;
    else       run <= want_s & ~peer_busy_s;
  end

  // Gate moves on the falling edge, so it changes only while the clock is low
  always_ff @(negedge clk) begin
    if (rst_s) gate <= RESET_ON;
    else       gate <= run;
  end

endmodule

// File: rtl/cpu_clock_switch.sv
module cpu_clock_switch
  import cksw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst,
  input  logic sel_b,
  output logic sys_clk,
  output logic cpu_a_en,
  output logic cpu_b_en
);

  localparam bit A_ON_RESET = (RESET_SRC == SRC_A);
  localparam bit B_ON_RESET = (RESET_SRC == SRC_B);

  src_e req_src;
  logic want_a, want_b;
  logic run_a, run_b;
  logic gate_a, gate_b;

  assign req_src = src_e'(sel_b);
  assign want_a  = (req_src == SRC_A);
  assign want_b  = (req_src == SRC_B);

  cksw_branch #(.STAGES(SYNC_STAGES), .RESET_ON(A_ON_RESET)) u_branch_a (
    .clk       (clk_a),
    .rst       (rst),
    .want      (want_a),
    .peer_gate (gate_b),
    .run       (run_a),
    .gate      (gate_a)
  );

  cksw_branch #(.STAGES(SYNC_STAGES), .RESET_ON(B_ON_RESET)) u_branch_b (
    .clk       (clk_b),
    .rst       (rst),
    .want      (want_b),
    .peer_gate (gate_a),
    .run       (run_b),
    .gate      (gate_b)
  );

  assign cpu_a_en = run_a;
  assign cpu_b_en = run_b;
  assign sys_clk  = (clk_a & gate_a) | (clk_b & gate_b);

endmodule

// File: rtl/cksw_checker.sv
module cksw_checker (
  input logic clk_a,
  input logic clk_b,
  input logic rst,
  input logic cpu_a_en,
  input logic cpu_b_en,
  input logic gate_a,
  input logic gate_b
);

  assert_excl_en_a_R3: assert property (@(posedge clk_a) disable iff (rst)
    !(cpu_a_en && cpu_b_en));

  assert_excl_en_b_R3: assert property (@(posedge clk_b) disable iff (rst)
    !(cpu_a_en && cpu_b_en));

  assert_gate_on_a_R5: assert property (@(posedge clk_a) disable iff (rst)
    $rose(cpu_a_en) |=> gate_a);

  assert_gate_on_b_R5: assert property (@(posedge clk_b) disable iff (rst)
    $rose(cpu_b_en) |=> gate_b);

  assert_gate_off_a_R4: assert property (@(posedge clk_a) disable iff (rst)
    $fell(cpu_a_en) |=> !gate_a);

  assert_gate_off_b_R4: assert property (@(posedge clk_b) disable iff (rst)
    $fell(cpu_b_en) |=> !gate_b);

  assert_order_a_R4: assert property (@(posedge clk_a) disable iff (rst)
    $rose(cpu_a_en) |-> !gate_b);

  assert_order_b_R4: assert property (@(posedge clk_b) disable iff (rst)
    $rose(cpu_b_en) |-> !gate_a);

endmodule

bind cpu_clock_switch cksw_checker u_cksw_checker (
  .clk_a    (clk_a),
  .clk_b    (clk_b),
  .rst      (rst),
  .cpu_a_en (cpu_a_en),
  .cpu_b_en (cpu_b_en),
  .gate_a   (gate_a),
  .gate_b   (gate_b)
);

// File: tb/test_cpu_clock_switch.sv
`timescale 1ns/1ps
module test_cpu_clock_switch;

  localparam realtime HALF_A   = 10.0;
  localparam realtime HALF_B   = 13.5;
  localparam realtime EPS      = 0.01;
  localparam realtime MAX_LAT  = 12 * 2 * HALF_B;

  typedef struct packed {
    logic src;
    logic change;
  } item_t;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst   = 1'b1;
  logic sel_b = 1'b0;
  logic sys_clk, cpu_a_en, cpu_b_en;

  int n_checks = 0;
  int n_fails  = 0;
  bit checking = 1'b0;
  bit done     = 1'b0;
  item_t exp_q[$];

  realtime t_rise = 0.0;
  realtime t_fall = 0.0;
  realtime last_high = 0.0;
  bit seen_rise = 1'b0;
  bit seen_fall = 1'b0;

  always #(HALF_A) clk_a = ~clk_a;
  initial begin
    #3.1;
    forever #(HALF_B) clk_b = ~clk_b;
  end

  cpu_clock_switch i_cpu_clock_switch (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst      (rst),
    .sel_b    (sel_b),
    .sys_clk  (sys_clk),
    .cpu_a_en (cpu_a_en),
    .cpu_b_en (cpu_b_en)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input realtime act, input realtime expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f at %0t", req, what, act, expv, $realtime);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  // Pulse-width monitor on the system clock (R5)
  always @(posedge sys_clk) begin
    if (checking && seen_fall)
      check(($realtime - t_fall) >= HALF_A - EPS, "R5", "low phase width",
            $realtime - t_fall, HALF_A);
    t_rise = $realtime;
    seen_rise = 1'b1;
  end

  always @(negedge sys_clk) begin
    if (seen_rise) begin
      last_high = $realtime - t_rise;
      if (checking)
        check((last_high > HALF_A - EPS && last_high < HALF_A + EPS) ||
              (last_high > HALF_B - EPS && last_high < HALF_B + EPS),
              "R5", "high phase width", last_high, HALF_A);
    end
    t_fall = $realtime;
    seen_fall = 1'b1;
  end

  // Enables must never overlap (R3)
  initial begin
    #0.7;
    forever begin
      #1;
      if (checking)
        check(!(cpu_a_en && cpu_b_en), "R3", "both enables high", 1.0, 0.0);
    end
  end

  // Driver: move the request and push what the design must do
  task automatic request(input bit b, input int hold_ns);
    item_t it;
    it.src    = b;
    it.change = (b != sel_b);
    exp_q.push_back(it);
    sel_b = b;
    #(hold_ns * 1.0);
  endtask

  // Monitor: pop each expected handover and compare
  initial begin
    item_t it;
    realtime t0, t_old_fall, t_new_rise;
    bit fell_seen;
    int waited;
    forever begin
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      t0 = $realtime;
      if (!it.change) begin
        for (int k = 0; k < 300; k++) begin
          #1;
          check(cpu_b_en == it.src && cpu_a_en == !it.src, "R7",
                "enable moved on repeated request", real'(cpu_b_en), real'(it.src));
        end
        @(negedge sys_clk);
        check(last_high > (it.src ? HALF_B : HALF_A) - EPS &&
              last_high < (it.src ? HALF_B : HALF_A) + EPS,
              "R7", "source changed on repeated request", last_high,
              it.src ? HALF_B : HALF_A);
      end else begin
        fell_seen = 1'b0;
        t_old_fall = 0.0;
        waited = 0;
        while (!(it.src ? cpu_b_en : cpu_a_en) && waited < 500) begin
          #1;
          waited++;
          if (!fell_seen && !(it.src ? cpu_a_en : cpu_b_en)) begin
            fell_seen = 1'b1;
            t_old_fall = $realtime;
          end
        end
        t_new_rise = $realtime;
        check(waited < 500, "R2", "incoming enable never rose", real'(waited), 0.0);
        check(fell_seen && t_old_fall < t_new_rise, "R4", "old enable fall time",
              t_old_fall, t_new_rise);
        check(t_rise <= t_old_fall + EPS, "R4", "output edge inside gap",
              t_rise, t_old_fall);
        check(t_new_rise - t0 <= MAX_LAT, "R6", "handover latency",
              t_new_rise - t0, MAX_LAT);
        repeat (3) @(negedge sys_clk);
        #0.3;
        check(last_high > (it.src ? HALF_B : HALF_A) - EPS &&
              last_high < (it.src ? HALF_B : HALF_A) + EPS,
              "R2", "system clock source after handover", last_high,
              it.src ? HALF_B : HALF_A);
        check(cpu_b_en == it.src && cpu_a_en == !it.src, "R2",
              "final enable pair", real'(cpu_b_en), real'(it.src));
      end
    end
  end

  // Watchdog
  initial begin
    #150_000;
    if (!done) begin
      check(1'b0, "R6", "watchdog expired", $realtime, 0.0);
      finish_run();
    end
  end

  initial begin
    #200.3;
    check(cpu_a_en == 1'b1 && cpu_b_en == 1'b0, "R1", "enables during reset",
          real'(cpu_b_en), 0.0);
    rst = 1'b0;
    #200;
    checking = 1'b1;
    @(negedge sys_clk);
    #0.3;
    check(cpu_a_en == 1'b1 && cpu_b_en == 1'b0, "R1", "enables after reset",
          real'(cpu_b_en), 0.0);
    check(last_high > HALF_A - EPS && last_high < HALF_A + EPS, "R1",
          "system clock after reset", last_high, HALF_A);
    #7.2;
    // Directed patterns: switch, back, repeat, switch, repeat
    request(1'b1, 700);
    request(1'b0, 700);
    request(1'b0, 700);
    request(1'b1, 900);
    request(1'b1, 700);
    request(1'b0, 650);
    // Random request times and values
    for (int i = 0; i < 24; i++) begin
      request(1'($urandom_range(0, 1)), $urandom_range(650, 1500));
    end
    wait (exp_q.size() == 0);
    #700;
    done = 1'b1;
    finish_run();
  end

endmodule